// File: doc/BRIEF.md
# Per-Lane Signed-Count Vector Shifter

This block shifts or rotates every element of a 128-bit vector by its own amount. The amount for an element comes from the element in the same position of a second 128-bit vector, called the count vector. The amount is read as a signed number. Its sign sets the direction: a positive count moves bits toward the most significant end, and a negative count moves them toward the least significant end. There is no separate opcode for left and right.

One operation applies to all lanes in a cycle. It is one of three kinds: rotate, arithmetic shift or logical shift. The lane width is 8, 16, 32 or 64 bits. Data never crosses a lane boundary.

The result is registered, so it appears one clock after the request. A small state machine tracks the output. It has two states:
- `ST_IDLE`: no fresh result is present.
- `ST_RESULT`: a result captured on the last edge is present.

Its transitions are:
- `GO_ISSUE`: any state goes to `ST_RESULT` when `in_valid` is high.
- `GO_DRAIN`: `ST_RESULT` goes to `ST_IDLE` when `in_valid` is low.
- `STAY_IDLE`: `ST_IDLE` stays in `ST_IDLE` when `in_valid` is low.

Top module: `vshift_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `data_out` is all zeros.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. In that same cycle `data_out` carries the result computed from the inputs sampled with `in_valid`.
- R3: In a cycle with `in_valid` low, `data_out` keeps its previous value.
- R4: The `lane_size` encoding is:
  - 0 selects 8-bit lanes.
  - 1 selects 16-bit lanes.
  - 2 selects 32-bit lanes.
  - 3 selects 64-bit lanes.

  Lane k occupies bits [k*W +: W]. The count of lane k is the two's-complement byte at `count_in[k*W +: 8]`. All other count bits are ignored.
- R5: A positive count moves bits toward the MSB (left). A negative count moves them toward the LSB (right), by the magnitude of the count.
- R6: Rotate (`op_kind` 0) moves bits by the magnitude modulo W. Bits leaving one end enter the other.
- R7: Logical shift (`op_kind` 2) fills vacated bits with 0. A magnitude of W or more gives an all-zero lane.
- R8: Arithmetic shift (`op_kind` 1) works as follows:
  - A right shift fills vacated bits with the lane's sign bit.
  - A right magnitude of W or more gives the sign bit in every position.
  - A left shift behaves exactly like a logical left shift.
- R9: A count of zero returns the lane unchanged for every operation kind.
- R10: `op_kind` 3 behaves exactly like a logical shift.
- R11: Lanes are independent. No bit of one lane's result depends on another lane's data or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request: operands are sampled on this edge |
| op_kind | input | 2 | 0 rotate, 1 arithmetic shift, 2 and 3 logical shift |
| lane_size | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit, 3: 64-bit lanes |
| data_in | input | 128 | Vector to be shifted |
| count_in | input | 128 | Per-lane counts (signed low byte of each lane) |
| out_valid | output | 1 | Result present on `data_out` |
| data_out | output | 128 | Registered result vector |

## Verification
Directed cases each isolate one rule:
- counts of +1 against -1 separate the two directions;
- a count of exactly W separates rotate, which returns the lane, from logical shift, which clears it;
- a count of -128 on 64-bit lanes separates arithmetic fill from logical fill;
- an all-ones byte vector shifted by one shows that no bit crosses into a neighbouring lane;
- junk placed in the upper count bits confirms that only the low byte is read.

Random operands across all kinds and sizes then mix positive, negative, small and out-of-range counts in neighbouring lanes. They are checked against a bit-by-bit reference model.

// File: rtl/vshift_pkg.sv
package vshift_pkg;

    localparam int VEC_W   = 128;
    localparam int CNT_W   = 8;
    localparam int N_SIZES = 4;

    typedef enum logic [1:0] {
        OP_ROT  = 2'd0,
        OP_SHA  = 2'd1,
        OP_SHL  = 2'd2,
        OP_SHL2 = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1
    } out_state_e;

    function automatic int lane_width(input int size_code);
        return 8 << size_code;
    endfunction

endpackage

// File: rtl/vshift_lane.sv
module vshift_lane
    import vshift_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]     lane_in,
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       op,
    output logic [W-1:0]     lane_out
);
    localparam int AW = $clog2(W);

    logic           neg;
    logic [CNT_W:0] mag;
    logic           big;
    logic [AW-1:0]  rot_amt;
    logic [AW-1:0]  rot_left;
    logic [2*W-1:0] dbl;
    logic [W-1:0]   rot_v;
    logic [W-1:0]   shl_v;
    logic [W-1:0]   shr_v;
    logic [W-1:0]   sra_v;

    always_comb begin
        neg      = cnt[CNT_W-1];
        mag      = neg ? ((CNT_W+1)'(0) - {cnt[CNT_W-1], cnt}) : {1'b0, cnt};
        big      = (mag >= (CNT_W+1)'(W));
        rot_amt  = mag[AW-1:0];
        rot_left = neg ? (AW'(0) - rot_amt) : rot_amt;
        dbl      = {lane_in, lane_in} << rot_left;
        rot_v    = dbl[2*W-1:W];
        shl_v    = big ? '0 : (lane_in << mag);
        shr_v    = big ? '0 : (lane_in >> mag);
        sra_v    = big ? {W{lane_in[W-1]}} : W'($signed(lane_in) >>> mag);
        unique case (op)
            OP_ROT:  lane_out = rot_v;
            OP_SHA:  lane_out = neg ? sra_v : shl_v;
            default: lane_out = neg ? shr_v : shl_v;
        endcase
    end

endmodule

// File: rtl/vshift_array.sv
module vshift_array
    import vshift_pkg::*;
(
    input  logic [VEC_W-1:0] vec_in,
    input  logic [VEC_W-1:0] cnt_vec,
    input  logic [1:0]       op,
    input  logic [1:0]       size_sel,
    output logic [VEC_W-1:0] vec_out
);
    logic [VEC_W-1:0] by_size [N_SIZES];

    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        localparam int W = 8 << g;
        localparam int N = VEC_W / W;
        logic [VEC_W-1:0] part;
        for (genvar k = 0; k < N; k++) begin : g_lane
            vshift_lane #(.W(W)) u_lane (
                .lane_in  (vec_in[k*W +: W]),
                .cnt      (cnt_vec[k*W +: CNT_W]),
                .op       (op),
                .lane_out (part[k*W +: W])
            );
        end
        assign by_size[g] = part;
    end

    always_comb begin
        unique case (size_sel)
            2'd0:    vec_out = by_size[0];
            2'd1:    vec_out = by_size[1];
            2'd2:    vec_out = by_size[2];
            default: vec_out = by_size[3];
        endcase
    end

endmodule

// File: rtl/vshift_unit.sv
module vshift_unit
    import vshift_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   op_kind,
    input  logic [1:0]   lane_size,
    input  logic [127:0] data_in,
    input  logic [127:0] count_in,
    output logic         out_valid,
    output logic [127:0] data_out
);
    out_state_e       state_q;
    out_state_e       state_d;
    logic [VEC_W-1:0] result_c;

    vshift_array u_array (
        .vec_in   (data_in),
        .cnt_vec  (count_in),
        .op       (op_kind),
        .size_sel (lane_size),
        .vec_out  (result_c)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        data_out <= '0;
        else if (in_valid) data_out <= result_c;
    end

    assign out_valid = (state_q == ST_RESULT);

endmodule

// File: rtl/vshift_checker.sv
module vshift_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [1:0]   op_kind,
    input logic [1:0]   lane_size,
    input logic [127:0] data_in,
    input logic [127:0] count_in,
    input logic         out_valid,
    input logic [127:0] data_out
);
    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_state_r1: assert (!out_valid && data_out == '0)
                else $error("reset state wrong");
        end
    end

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_output_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(data_out));

    p_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && count_in == '0) |=> data_out == $past(data_in));

    p_rotate_keeps_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'd0) |=> $countones(data_out) == $countones($past(data_in)));

    p_sign_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'd1 && lane_size == 2'd3 && count_in[7:0] == 8'h80)
        |=> data_out[63:0] == {64{$past(data_in[63])}});

endmodule

bind vshift_unit vshift_checker u_vshift_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_kind   (op_kind),
    .lane_size (lane_size),
    .data_in   (data_in),
    .count_in  (count_in),
    .out_valid (out_valid),
    .data_out  (data_out)
);

// File: tb/tb_vshift_unit.sv
module tb_vshift_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   op_kind = '0;
    logic [1:0]   lane_size = '0;
    logic [127:0] data_in = '0;
    logic [127:0] count_in = '0;
    logic         out_valid;
    logic [127:0] data_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vshift_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_kind   (op_kind),
        .lane_size (lane_size),
        .data_in   (data_in),
        .count_in  (count_in),
        .out_valid (out_valid),
        .data_out  (data_out)
    );

    function automatic logic [127:0] model(input logic [1:0] op, input logic [1:0] sz,
                                           input logic [127:0] d, input logic [127:0] c);
        logic [127:0] r = '0;
        int w = 8 << sz;
        for (int l = 0; l < 128 / w; l++) begin
            logic [63:0] x = '0;
            logic [7:0]  cb;
            int cnt, m, src;
            for (int b = 0; b < w; b++) x[b] = d[l*w + b];
            for (int b = 0; b < 8; b++) cb[b] = c[l*w + b];
            cnt = $signed(cb);
            m = (cnt < 0) ? -cnt : cnt;
            for (int b = 0; b < w; b++) begin
                logic bitv;
                if (op == 2'd0) begin
                    src = (cnt >= 0) ? ((b - (m % w) + w) % w) : ((b + m) % w);
                    bitv = x[src];
                end else if (cnt >= 0) begin
                    src = b - m;
                    bitv = (src >= 0) ? x[src] : 1'b0;
                end else begin
                    src = b + m;
                    bitv = (src < w) ? x[src] : ((op == 2'd1) ? x[w-1] : 1'b0);
                end
                r[l*w + b] = bitv;
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_case(input string req, input logic [1:0] op, input logic [1:0] sz,
                            input logic [127:0] d, input logic [127:0] c);
        logic [127:0] exp;
        exp = model(op, sz, d, c);
        @(negedge clk);
        in_valid = 1'b1; op_kind = op; lane_size = sz; data_in = d; count_in = c;
        @(negedge clk);
        check({req, " R2 valid"}, {127'd0, out_valid}, 128'd1);
        check(req, data_out, exp);
        in_valid = 1'b0;
    endtask

    function automatic logic [127:0] rep8(input logic [7:0] v);
        return {16{v}};
    endfunction

    initial begin
        #4000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [127:0] held;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 valid", {127'd0, out_valid}, 128'd0);
        check("R1 data", data_out, '0);
        rst_n = 1'b1;

        run_case("R5 left", 2'd2, 2'd0, rep8(8'h21), rep8(8'h01));
        run_case("R5 right", 2'd2, 2'd0, rep8(8'h21), rep8(8'hFF));
        run_case("R6 rot mod", 2'd0, 2'd0, rep8(8'h96), rep8(8'h0D));
        run_case("R6 rot neg", 2'd0, 2'd1, {8{16'h8001}}, {8{16'h00FD}});
        run_case("R7 full width", 2'd2, 2'd0, rep8(8'hA5), rep8(8'h08));
        run_case("R6 full width", 2'd0, 2'd0, rep8(8'hA5), rep8(8'h08));
        run_case("R8 sign fill", 2'd1, 2'd3, {64'h8000_0000_0000_0001, 64'h8123_0000_0000_0000},
                 {64'h80, 64'h80});
        run_case("R7 no sign fill", 2'd2, 2'd3, {64'h8000_0000_0000_0001, 64'h8123_0000_0000_0000},
                 {64'h80, 64'h80});
        run_case("R8 arith left", 2'd1, 2'd2, {4{32'hC000_0003}}, {4{32'h0000_0002}});
        run_case("R8 arith right", 2'd1, 2'd2, {4{32'h8000_0010}}, {4{32'h0000_00FC}});
        run_case("R9 zero count", 2'd1, 2'd1, {4{32'hDEAD_BEEF}}, '0);
        run_case("R4 upper bits ignored", 2'd2, 2'd1, {8{16'h0F0F}}, {8{16'hFF03}});
        run_case("R10 op3 logical", 2'd3, 2'd2, {4{32'hF000_000F}}, {4{32'hFFFF_FFFC}});
        run_case("R11 no crossing", 2'd2, 2'd0, {16{8'hFF}}, rep8(8'h01));

        held = data_out;
        @(negedge clk);
        in_valid = 1'b0; data_in = ~data_in; count_in = rep8(8'h03);
        @(negedge clk);
        check("R3 hold", data_out, held);
        check("R2 drop", {127'd0, out_valid}, 128'd0);

        for (int n = 0; n < 300; n++) begin
            logic [127:0] d, c;
            d = {$urandom, $urandom, $urandom, $urandom};
            c = {$urandom, $urandom, $urandom, $urandom};
            if (n % 2 == 0) begin
                for (int b = 0; b < 16; b++) c[b*8 +: 8] = 8'($signed(6'($urandom)));
            end
            run_case("R11 random", 2'($urandom), 2'($urandom), d, c);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule